// File: doc/BRIEF.md
# Command-Mode SPI Flash Controller

A single-command SPI master that sits behind a byte-wide register port. Software loads an opcode, a transmit count, a receive count and a target number, writes the outgoing payload into a shared 72-byte buffer, and then fires a start bit. The engine selects the target, shifts out the opcode, then the payload, and then clocks in the requested number of reply bytes. The reply bytes are placed in the same buffer, right behind the payload.

The bus is half-duplex, SPI mode 0, MSB first. The serial clock is the system clock divided by `2*HALF_DIV`. A status bit stays high for the whole command. Commands are issued one at a time and polled to completion.

Buffer accesses go through an engine pointer. The pointer advances by one for each payload byte sent and for each reply byte stored. It is cleared only by an explicit clear bit, so software normally clears it before loading each command.

Top module: `spi_cmd_ctrl`

## Requirements
- R1: After reset, the status bit reads 0, every `spi_cs_n` line is high, `spi_sclk` is low, and the opcode, count and target registers read 0. Every buffer byte reads 0.
- R2: Register offsets:
  - target field: byte 0x1D, bits [1:0]
  - opcode: 0x45
  - transmit count: 0x48
  - receive count: 0x4B
  - buffer: 0x80 to 0xC7, where byte i sits at 0x80+i

  Each of these reads back the value last written.
- R3: Writing a byte with bit 7 set to offset 0x47 while idle starts a command. The status bit (byte 0x4F, bit 7) reads 1 from the cycle after that write. It falls exactly (16*HALF_DIV+2)*(1+TXE+RXE) cycles after the write edge, where TXE and RXE are the effective counts of R8.
- R4: The engine sends the opcode first. It then sends TXE buffer bytes starting at the engine pointer. Each byte goes out MSB first, with `spi_mosi` stable across every rising `spi_sclk` edge. A command gives exactly 8*(1+TXE+RXE) rising edges.
- R5: Reply byte n is sampled from `spi_miso` on rising edges, MSB first. It is stored at buffer index (pointer at start + TXE + n); with a cleared pointer that is offset 0x80+TXE+n.
- R6: While a command runs, only the `spi_cs_n` line numbered by the target field is low. All lines are high while idle.
- R7: A start write made while busy is ignored. An opcode write made while busy does not change the command in flight.
- R8: Counts are clamped. TXE = min(transmit count, 72) and RXE = min(receive count, 72 - TXE).
- R9: With both counts 0, only the opcode byte is sent, and busy falls after 16*HALF_DIV+2 cycles.
- R10: The engine pointer carries over from one command to the next. Writing bit 4 of byte 0x02 while idle resets it to 0. Buffer indices at or beyond 72 send zero bytes and discard reply bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe for one cycle |
| reg_addr | input | 8 | Byte offset for reads and writes |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte, combinational from `reg_addr` |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | NCS | Active-low target selects |

## Verification
The status bit is due in the first cycle after the start write. The bench samples it at the falling clock edge that follows that write edge. Each byte then costs 16*HALF_DIV shift cycles plus two hand-off cycles. The bench therefore counts falling edges from the start write and expects busy still high one cycle before the computed end and low exactly at it. The serial stream and the reply placement are compared only after busy has dropped, against a bench model of the buffer and the pointer. The chip-select pattern is sampled halfway through the opcode byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPC  = 2'd1,
        PH_TX   = 2'd2,
        PH_RX   = 2'd3
    } phase_e;

    localparam logic [7:0] OFS_CTRL_B2 = 8'h02;
    localparam logic [7:0] OFS_CS      = 8'h1D;
    localparam logic [7:0] OFS_OPC     = 8'h45;
    localparam logic [7:0] OFS_GO      = 8'h47;
    localparam logic [7:0] OFS_TXN     = 8'h48;
    localparam logic [7:0] OFS_RXN     = 8'h4B;
    localparam logic [7:0] OFS_STAT_B3 = 8'h4F;
    localparam logic [7:0] OFS_BUF     = 8'h80;

endpackage

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
    parameter int DEPTH = 72,
    parameter int IW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [IW-1:0] a_idx,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [IW-1:0] b_idx,
    input  logic [7:0]    b_wdata,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem_q [DEPTH];

    // engine port is written last so it wins on a same-index collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (a_we && a_idx < IW'(DEPTH)) mem_q[a_idx] <= a_wdata;
            if (b_we && b_idx < IW'(DEPTH)) mem_q[b_idx] <= b_wdata;
        end
    end

    assign a_rdata = (a_idx < IW'(DEPTH)) ? mem_q[a_idx] : '0;
    assign b_rdata = (b_idx < IW'(DEPTH)) ? mem_q[b_idx] : '0;

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);
    localparam int CW = $clog2(HALF_DIV + 1);

    typedef struct packed {
        logic          active;
        logic          sclk;
        logic [CW-1:0] cnt;
        logic [2:0]    nbit;
        logic [7:0]    tx_sh;
        logic [7:0]    rx_sh;
        logic          done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.active) begin
            d.active = 1'b1;
            d.sclk   = 1'b0;
            d.cnt    = '0;
            d.nbit   = '0;
            d.tx_sh  = tx_byte;
        end else if (q.active) begin
            if (q.cnt == CW'(HALF_DIV - 1)) begin
                d.cnt = '0;
                if (!q.sclk) begin
                    d.sclk  = 1'b1;
                    d.rx_sh = {q.rx_sh[6:0], miso};
                end else begin
                    d.sclk = 1'b0;
                    if (q.nbit == 3'd7) begin
                        d.active = 1'b0;
                        d.done   = 1'b1;
                    end else begin
                        d.nbit  = q.nbit + 3'd1;
                        d.tx_sh = {q.tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk    = q.sclk;
    assign mosi    = q.active ? q.tx_sh[7] : 1'b0;
    assign rx_byte = q.rx_sh;
    assign done    = q.done;

    // R4: the sequencer never launches a byte over one in flight
    a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.active);

    // R4: data line holds still while the clock is high
    a_r4_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sclk && $past(q.sclk)) |-> $stable(mosi));

endmodule

// File: rtl/spi_cmd_csdec.sv
module spi_cmd_csdec #(
    parameter int NCS = 4,
    parameter int SW  = $clog2(NCS)
) (
    input  logic           en,
    input  logic [SW-1:0]  sel,
    output logic [NCS-1:0] cs_n
);
    for (genvar g = 0; g < NCS; g++) begin : g_cs
        assign cs_n[g] = ~(en && (sel == SW'(g)));
    end
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH    = 72,
    parameter int HALF_DIV = 2,
    parameter int NCS      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [7:0]     reg_addr,
    input  logic [7:0]     reg_wdata,
    output logic [7:0]     reg_rdata,
    output logic           spi_sclk,
    output logic           spi_mosi,
    input  logic           spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    localparam int         IW      = $clog2(DEPTH + 1);
    localparam int         SW      = $clog2(NCS);
    localparam logic [7:0] DEPTH_B = 8'(DEPTH);
    localparam logic [8:0] BUF_END = 9'(OFS_BUF) + 9'(DEPTH);

    typedef struct packed {
        logic [7:0]    opc;
        logic [7:0]    txn;
        logic [7:0]    rxn;
        logic [SW-1:0] sel;
        logic          busy;
        phase_e        phase;
        logic [7:0]    tx_left;
        logic [7:0]    rx_left;
        logic [IW-1:0] ptr;
        logic          start;
        logic [7:0]    tx_byte;
    } ctl_t;

    ctl_t q, d;

    logic          in_buf, go, clr;
    logic [IW-1:0] host_idx;
    logic [7:0]    host_rd, eng_rd, sh_rx;
    logic          eng_we, sh_done;
    logic [7:0]    tx_eff, rx_eff, room;

    function automatic logic [IW-1:0] inc_sat(input logic [IW-1:0] p);
        return (p >= IW'(DEPTH)) ? p : p + IW'(1);
    endfunction

    // host decode
    assign in_buf   = ({1'b0, reg_addr} >= 9'(OFS_BUF)) && ({1'b0, reg_addr} < BUF_END);
    assign host_idx = IW'(reg_addr - OFS_BUF);
    assign go       = reg_wr && (reg_addr == OFS_GO) && reg_wdata[7];
    assign clr      = reg_wr && (reg_addr == OFS_CTRL_B2) && reg_wdata[4];

    // count clamping
    assign tx_eff = (q.txn > DEPTH_B) ? DEPTH_B : q.txn;
    assign room   = DEPTH_B - tx_eff;
    assign rx_eff = (q.rxn > room) ? room : q.rxn;

    // reply byte lands where the pointer stands
    assign eng_we = q.busy && sh_done && (q.phase == PH_RX);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                OFS_CS:  d.sel = reg_wdata[SW-1:0];
                OFS_OPC: d.opc = reg_wdata;
                OFS_TXN: d.txn = reg_wdata;
                OFS_RXN: d.rxn = reg_wdata;
                default: ;
            endcase
        end
        if (!q.busy) begin
            if (clr) d.ptr = '0;
            if (go) begin
                d.busy    = 1'b1;
                d.phase   = PH_OPC;
                d.tx_left = tx_eff;
                d.rx_left = rx_eff;
                d.start   = 1'b1;
                d.tx_byte = q.opc;
            end
        end else if (sh_done) begin
            if (q.tx_left != 8'd0) begin
                d.start   = 1'b1;
                d.tx_byte = eng_rd;
                d.ptr     = inc_sat(q.ptr);
                d.tx_left = q.tx_left - 8'd1;
                d.phase   = PH_TX;
            end else begin
                if (q.phase == PH_RX) d.ptr = inc_sat(q.ptr);
                if (q.rx_left != 8'd0) begin
                    d.start   = 1'b1;
                    d.tx_byte = 8'h00;
                    d.rx_left = q.rx_left - 8'd1;
                    d.phase   = PH_RX;
                end else begin
                    d.busy  = 1'b0;
                    d.phase = PH_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        if (in_buf) begin
            reg_rdata = host_rd;
        end else begin
            case (reg_addr)
                OFS_CS:      reg_rdata = 8'(q.sel);
                OFS_OPC:     reg_rdata = q.opc;
                OFS_TXN:     reg_rdata = q.txn;
                OFS_RXN:     reg_rdata = q.rxn;
                OFS_STAT_B3: reg_rdata = {q.busy, 7'b0};
                default:     reg_rdata = '0;
            endcase
        end
    end

    spi_cmd_buf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_we    (reg_wr && in_buf),
        .a_idx   (host_idx),
        .a_wdata (reg_wdata),
        .a_rdata (host_rd),
        .b_we    (eng_we),
        .b_idx   (q.ptr),
        .b_wdata (sh_rx),
        .b_rdata (eng_rd)
    );

    spi_cmd_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (q.start),
        .tx_byte (q.tx_byte),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .rx_byte (sh_rx),
        .done    (sh_done)
    );

    spi_cmd_csdec #(.NCS(NCS), .SW(SW)) u_cs (
        .en   (q.busy),
        .sel  (q.sel),
        .cs_n (spi_cs_n)
    );

    // R3: an accepted start raises busy on the next edge
    a_r3_busy_set: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !q.busy) |=> q.busy);

    // R7: busy only drops on a byte completion from the shifter
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !sh_done) |=> q.busy);

    // R6: never more than one target selected
    a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~spi_cs_n));

    // R6: every select released while idle
    a_r6_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (&spi_cs_n));

endmodule

// File: tb/spi_cmd_ctrl_test.sv
module spi_cmd_ctrl_test;
    localparam int CLK_PER = 10;
    localparam int HALF    = 2;
    localparam int DEPTH   = 72;
    localparam int PB      = 16 * HALF + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_mosi, spi_miso;
    logic [3:0] spi_cs_n;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PER / 2) clk = ~clk;

    spi_cmd_ctrl #(.DEPTH(DEPTH), .HALF_DIV(HALF), .NCS(4)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // ---------------- target model ----------------
    function automatic logic [7:0] slave_byte(input int i);
        return 8'(8'h3C + i * 17);
    endfunction

    function automatic logic slave_bit(input logic [15:0] c);
        logic [7:0] b;
        b = slave_byte(int'(c[15:3]));
        return b[~c[2:0]];
    endfunction

    logic        cs_idle;
    logic [15:0] rise_cnt = '0;
    logic [7:0]  mosi_log [128];
    logic [3:0]  cs_seen = '0;

    assign cs_idle  = &spi_cs_n;
    assign spi_miso = slave_bit(rise_cnt);

    always @(posedge spi_sclk or negedge cs_idle) begin
        if (!spi_sclk) begin
            rise_cnt <= '0;
        end else begin
            mosi_log[rise_cnt[9:3]][~rise_cnt[2:0]] <= spi_mosi;
            rise_cnt <= rise_cnt + 16'd1;
        end
    end

    always @(negedge cs_idle) cs_seen = ~spi_cs_n;

    // ---------------- bench model ----------------
    logic [7:0] shadow [DEPTH];
    int         p_mdl = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic run_cmd(input logic [7:0] opc, input int txn, input int rxn,
                           input int sel, input bit clr, input bit retrig, input string tag);
        int txe, rxe, n, mism;
        logic [7:0] v, ex;
        if (clr) begin
            wr(8'h02, 8'h10);
            p_mdl = 0;
            for (int i = 0; i < ((txn > DEPTH) ? DEPTH : txn); i++) begin
                v = 8'(int'(opc) + i * 7 + 1);
                wr(8'h80 + 8'(i), v);
                shadow[i] = v;
            end
        end
        wr(8'h1D, 8'(sel));
        wr(8'h45, opc);
        wr(8'h48, 8'(txn));
        wr(8'h4B, 8'(rxn));
        txe = (txn > DEPTH) ? DEPTH : txn;
        rxe = (rxn > DEPTH - txe) ? DEPTH - txe : rxn;
        n   = 1 + txe + rxe;
        // start write: takes effect on edge E0
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 8'h47; reg_wdata = 8'h80;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 8'h4F;
        #1 chk(reg_rdata[7] == 1'b1, {"R3 busy after start ", tag}, int'(reg_rdata[7]), 1);
        for (int c = 1; c <= n * PB; c++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 8'h4F;
            #1;
            if (c == PB / 2)
                chk(spi_cs_n == ~(4'b1 << sel), {"R6 select pattern ", tag},
                    int'(spi_cs_n), int'(~(4'b1 << sel)));
            if (c == n * PB - 1)
                chk(reg_rdata[7] == 1'b1, {"R3 busy held ", tag}, int'(reg_rdata[7]), 1);
            if (c == n * PB)
                chk(reg_rdata[7] == 1'b0, {"R3 busy drop ", tag}, int'(reg_rdata[7]), 0);
            if (retrig && c == 10) begin
                reg_wr = 1'b1; reg_addr = 8'h47; reg_wdata = 8'h80;
            end
            if (retrig && c == 12) begin
                reg_wr = 1'b1; reg_addr = 8'h45; reg_wdata = 8'hEE;
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
        chk(int'(rise_cnt) == 8 * n, {"R4 edge count ", tag}, int'(rise_cnt), 8 * n);
        chk(mosi_log[0] == opc, {"R4 opcode first ", tag}, int'(mosi_log[0]), int'(opc));
        chk(cs_seen == (4'b1 << sel), {"R6 selected line ", tag}, int'(cs_seen), int'(4'b1 << sel));
        mism = 0;
        for (int i = 0; i < txe; i++) begin
            ex = (p_mdl < DEPTH) ? shadow[p_mdl] : 8'h00;
            if (mosi_log[1 + i] != ex) mism++;
            if (p_mdl < DEPTH) p_mdl++;
        end
        chk(mism == 0, {"R4 payload bytes ", tag}, mism, 0);
        for (int k = 0; k < rxe; k++) begin
            if (p_mdl < DEPTH) begin
                shadow[p_mdl] = slave_byte(1 + txe + k);
                p_mdl++;
            end
        end
        mism = 0;
        for (int i = 0; i < DEPTH; i++) begin
            rd(8'h80 + 8'(i), v);
            if (v != shadow[i]) mism++;
        end
        chk(mism == 0, {"R5 buffer contents ", tag}, mism, 0);
    endtask

    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] txn;
        logic [7:0] rxn;
        logic [1:0] sel;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{opc: 8'h9F, txn: 8'd0, rxn: 8'd3, sel: 2'd1},
        '{opc: 8'h03, txn: 8'd4, rxn: 8'd5, sel: 2'd2},
        '{opc: 8'h06, txn: 8'd0, rxn: 8'd0, sel: 2'd0},
        '{opc: 8'h02, txn: 8'd3, rxn: 8'd0, sel: 2'd3}
    };

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h4F, v); chk(v[7] == 1'b0, "R1 busy clear", int'(v[7]), 0);
        chk(spi_cs_n == 4'hF, "R1 selects high", int'(spi_cs_n), 15);
        chk(spi_sclk == 1'b0, "R1 clock low", int'(spi_sclk), 0);
        rd(8'h45, v); chk(v == 8'h00, "R1 opcode zero", int'(v), 0);
        rd(8'h48, v); chk(v == 8'h00, "R1 tx count zero", int'(v), 0);
        rd(8'h80, v); chk(v == 8'h00, "R1 buffer zero", int'(v), 0);

        // R2: readback
        wr(8'h45, 8'hA7); rd(8'h45, v); chk(v == 8'hA7, "R2 opcode readback", int'(v), 167);
        wr(8'h4B, 8'h21); rd(8'h4B, v); chk(v == 8'h21, "R2 rx count readback", int'(v), 33);
        wr(8'h1D, 8'h02); rd(8'h1D, v); chk(v == 8'h02, "R2 target readback", int'(v), 2);
        wr(8'hC7, 8'h5A); rd(8'hC7, v); chk(v == 8'h5A, "R2 last buffer byte", int'(v), 90);
        shadow[DEPTH - 1] = 8'h5A;

        // table walk: R3 R4 R5 R6, third entry is R9
        foreach (VECS[i])
            run_cmd(VECS[i].opc, int'(VECS[i].txn), int'(VECS[i].rxn),
                    int'(VECS[i].sel), 1'b1, 1'b0, $sformatf("vec%0d", i));

        // R9: zero counts, opcode only, checked again on a different target
        run_cmd(8'h05, 0, 0, 2, 1'b1, 1'b0, "R9 opcode only");

        // R10: pointer carries over, then a clear rewinds it
        run_cmd(8'h0B, 2, 1, 1, 1'b1, 1'b0, "R10 setup");
        run_cmd(8'h0C, 1, 0, 1, 1'b0, 1'b0, "R10 carried pointer");
        run_cmd(8'h0D, 1, 0, 1, 1'b1, 1'b0, "R10 cleared pointer");

        // R7: start and opcode writes while busy
        run_cmd(8'h4E, 0, 2, 3, 1'b1, 1'b1, "R7 start while busy");

        // R8: clamping
        run_cmd(8'h11, 80, 3, 0, 1'b1, 1'b0, "R8 tx over depth");
        run_cmd(8'h12, 70, 5, 2, 1'b1, 1'b0, "R8 sum over depth");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule